// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small processor core that completes every instruction in one clock cycle. All state is written on the same rising edge: the program counter, the register file and the data memory. The core fetches a 32-bit word from an internal instruction memory addressed by the PC. It decodes the word in two levels: a main control stage works on the opcode, and a local ALU control stage works on the function field of register-register instructions. It reads two source registers combinationally, executes, and writes the result back at the next edge.

The supported set is:
- add and subtract between registers,
- OR with a zero-extended immediate,
- word load and word store with a sign-extended offset,
- branch when two registers are equal,
- an absolute jump inside the current 256 MB region.

Both memories are word arrays held inside the core. They are read combinationally and written on the clock edge. A program port fills the instruction memory, normally while reset is held. A debug port shows the current PC and reads any register combinationally, so a test harness can observe the architectural state.

The design has no state machine. The two registered quantities are the PC and the storage arrays. Every instruction has the same single phase: fetch, decode, read, execute and write back, all in one cycle.

Top module: `sc_core`

## Requirements
- R1: Synchronous reset (`rst` high at a rising edge) sets the PC to 0 and clears all 32 registers. No instruction writes registers or data memory while `rst` is high.
- R2: Opcode 000000 is a register-register instruction. Function code 100000 writes R[rs]+R[rt] into R[rd], and function code 100010 writes R[rs]-R[rt] into R[rd]. Fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0].
- R3: Opcode 001101 writes R[rs] OR {16'b0, imm[15:0]} into R[rt], with zero extension of the immediate.
- R4: Opcode 100011 writes into R[rt] the data-memory word at byte address R[rs]+sign_extend(imm), word index address[DAW+1:2].
- R5: Opcode 101011 writes R[rt] into the data-memory word at R[rs]+sign_extend(imm). It writes no register.
- R6: Opcode 000100 compares R[rs] with R[rt] by subtraction. If they are equal, the next PC is PC+4+(sign_extend(imm)<<2); otherwise it is PC+4.
- R7: Opcode 000010 sets the PC to {(PC+4)[31:28], target[25:0], 2'b00}.
- R8: Every instruction other than a branch or a jump advances the PC by 4.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: An unknown opcode, or a register-register instruction with any other function code, changes nothing except advancing the PC by 4.
- R11: `prog_we` writes `prog_data` into instruction word `prog_addr` at the clock edge. The instruction word fetched for a PC is word PC[IAW+1:2]. `dbg_pc` shows the current PC, and `dbg_reg_data` shows R[`dbg_reg_sel`] combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction-memory write strobe |
| prog_addr | input | IAW | Instruction word index to write |
| prog_data | input | 32 | Instruction word to write |
| dbg_reg_sel | input | 5 | Register number to observe |
| dbg_reg_data | output | 32 | Contents of the selected register (zero for register 0) |
| dbg_pc | output | 32 | Current program counter (byte address) |

## Verification
Two effects are hard to see from the ports, and the program is laid out to expose each one.

A store changes nothing visible at the ports. The program therefore follows a store at a negative offset with a load from the same address into a fresh register. The stored data is also the result of a subtraction that wraps below zero. The bits of the store's immediate, read as a destination field, name register 31, so a wrongly enabled write would show up there. 

Both branch directions are exercised, as well as a jump over instructions that would otherwise write registers. The program ends with a backward branch and a jump that chase each other indefinitely. The PC trace is compared cycle by cycle, so the backward target arithmetic is checked on several iterations. A mid-run reset is applied last to show the clear of PC and registers.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;
    localparam int RIDX = 5;
    localparam int NREG = 32;

    // Opcode field values, bits [31:26]
    localparam logic [5:0] OP_REGREG = 6'b000000;
    localparam logic [5:0] OP_JMP    = 6'b000010;
    localparam logic [5:0] OP_BREQ   = 6'b000100;
    localparam logic [5:0] OP_ORIMM  = 6'b001101;
    localparam logic [5:0] OP_LDW    = 6'b100011;
    localparam logic [5:0] OP_STW    = 6'b101011;

    // Function field values, bits [5:0]
    localparam logic [5:0] FN_PLUS  = 6'b100000;
    localparam logic [5:0] FN_MINUS = 6'b100010;

    // What the main decoder asks of the ALU
    typedef enum logic [1:0] {
        CLS_FUNCT,
        CLS_OR,
        CLS_ADD,
        CLS_SUB
    } alu_cls_e;

    typedef struct packed {
        logic     dst_rd;
        logic     src_imm;
        logic     wb_mem;
        logic     reg_we;
        logic     mem_we;
        logic     branch;
        logic     jump;
        logic     ext_sign;
        alu_cls_e alu_cls;
    } ctrl_t;
endpackage

// File: rtl/sc_main_ctl.sv
module sc_main_ctl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctrl_t      ctl
);
    always_comb begin
        ctl.dst_rd   = 1'b0;
        ctl.src_imm  = 1'b0;
        ctl.wb_mem   = 1'b0;
        ctl.reg_we   = 1'b0;
        ctl.mem_we   = 1'b0;
        ctl.branch   = 1'b0;
        ctl.jump     = 1'b0;
        ctl.ext_sign = 1'b0;
        ctl.alu_cls  = CLS_ADD;
        unique case (opcode)
            OP_REGREG: begin
                ctl.dst_rd  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.alu_cls = CLS_FUNCT;
            end
            OP_ORIMM: begin
                ctl.src_imm = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.alu_cls = CLS_OR;
            end
            OP_LDW: begin
                ctl.src_imm  = 1'b1;
                ctl.ext_sign = 1'b1;
                ctl.wb_mem   = 1'b1;
                ctl.reg_we   = 1'b1;
                ctl.alu_cls  = CLS_ADD;
            end
            OP_STW: begin
                ctl.src_imm  = 1'b1;
                ctl.ext_sign = 1'b1;
                ctl.mem_we   = 1'b1;
                ctl.alu_cls  = CLS_ADD;
            end
            OP_BREQ: begin
                ctl.branch  = 1'b1;
                ctl.alu_cls = CLS_SUB;
            end
            OP_JMP: begin
                ctl.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  alu_cls_e         cls,
    input  logic [5:0]       funct,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic [XLEN-1:0]  res,
    output logic             zero,
    output logic             funct_ok
);
    typedef enum logic [1:0] {
        K_ADD,
        K_SUB,
        K_OR
    } kind_e;

    kind_e kind;

    // Local decode: class from main control, function field for reg-reg
    always_comb begin
        funct_ok = 1'b1;
        kind     = K_ADD;
        unique case (cls)
            CLS_FUNCT: begin
                if (funct == FN_PLUS) begin
                    kind = K_ADD;
                end else if (funct == FN_MINUS) begin
                    kind = K_SUB;
                end else begin
                    funct_ok = 1'b0;
                end
            end
            CLS_OR:  kind = K_OR;
            CLS_ADD: kind = K_ADD;
            CLS_SUB: kind = K_SUB;
            default: ;
        endcase
    end

    always_comb begin
        unique case (kind)
            K_ADD:   res = opa + opb;
            K_SUB:   res = opa - opb;
            K_OR:    res = opa | opb;
            default: res = opa + opb;
        endcase
    end

    assign zero = (res == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter  int DEPTH = 32,
    parameter  int WIDTH = 32,
    parameter  int NREAD = 3,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic [WIDTH-1:0]            wdata,
    input  logic [NREAD-1:0][AW-1:0]    raddr,
    output logic [NREAD-1:0][WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            cells[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : cells[raddr[p]];
    end
endmodule

// File: rtl/sc_pc_unit.sv
module sc_pc_unit
    import sc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            branch,
    input  logic            equal,
    input  logic            jump,
    input  logic [15:0]     offset,
    input  logic [25:0]     target,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;

    assign seq_pc = pc_q + 32'd4;
    assign br_pc  = seq_pc + {{(XLEN-18){offset[15]}}, offset, 2'b00};

    always_comb begin
        pc_d = seq_pc;
        if (jump) begin
            pc_d = {seq_pc[XLEN-1:XLEN-4], target, 2'b00};
        end else if (branch && equal) begin
            pc_d = br_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc = pc_q;
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter  int IMEM_WORDS = 64,
    parameter  int DMEM_WORDS = 64,
    localparam int IAW        = $clog2(IMEM_WORDS),
    localparam int DAW        = $clog2(DMEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_we,
    input  logic [IAW-1:0]   prog_addr,
    input  logic [XLEN-1:0]  prog_data,
    input  logic [RIDX-1:0]  dbg_reg_sel,
    output logic [XLEN-1:0]  dbg_reg_data,
    output logic [XLEN-1:0]  dbg_pc
);
    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] instr;

    logic [5:0]      f_op;
    logic [RIDX-1:0] f_rs;
    logic [RIDX-1:0] f_rt;
    logic [RIDX-1:0] f_rd;
    logic [5:0]      f_fn;
    logic [15:0]     f_imm;
    logic [25:0]     f_tgt;

    ctrl_t           ctl;
    logic [XLEN-1:0] ext_imm;
    logic [2:0][XLEN-1:0] rf_rd;
    logic [XLEN-1:0] bus_a;
    logic [XLEN-1:0] bus_b;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y;
    logic            alu_zero;
    logic            funct_ok;
    logic [RIDX-1:0] rf_waddr;
    logic [XLEN-1:0] rf_wdata;
    logic            rf_we;
    logic [XLEN-1:0] dmem_rdata;
    logic [DAW-1:0]  dmem_idx;
    logic            is_branch;
    logic            is_jump;
    logic            is_store;
    logic            unused_bits;

    // Instruction memory: program port write, combinational fetch
    always_ff @(posedge clk) begin
        if (prog_we) begin
            imem[prog_addr] <= prog_data;
        end
    end

    assign instr = imem[pc[IAW+1:2]];

    assign f_op  = instr[31:26];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_fn  = instr[5:0];
    assign f_imm = instr[15:0];
    assign f_tgt = instr[25:0];

    sc_main_ctl u_ctl (
        .opcode (f_op),
        .ctl    (ctl)
    );

    assign ext_imm = ctl.ext_sign ? {{(XLEN-16){f_imm[15]}}, f_imm}
                                  : {{(XLEN-16){1'b0}}, f_imm};

    sc_regfile #(
        .DEPTH (NREG),
        .WIDTH (XLEN),
        .NREAD (3)
    ) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr ({dbg_reg_sel, f_rt, f_rs}),
        .rdata (rf_rd)
    );

    assign bus_a        = rf_rd[0];
    assign bus_b        = rf_rd[1];
    assign dbg_reg_data = rf_rd[2];

    assign alu_b = ctl.src_imm ? ext_imm : bus_b;

    sc_alu u_alu (
        .cls      (ctl.alu_cls),
        .funct    (f_fn),
        .opa      (bus_a),
        .opb      (alu_b),
        .res      (alu_y),
        .zero     (alu_zero),
        .funct_ok (funct_ok)
    );

    // Data memory: combinational read, edge write
    assign dmem_idx   = alu_y[DAW+1:2];
    assign dmem_rdata = dmem[dmem_idx];

    always_ff @(posedge clk) begin
        if (!rst && ctl.mem_we) begin
            dmem[dmem_idx] <= bus_b;
        end
    end

    assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
    assign rf_wdata = ctl.wb_mem ? dmem_rdata : alu_y;
    assign rf_we    = ctl.reg_we && funct_ok && !rst;

    sc_pc_unit u_pc (
        .clk    (clk),
        .rst    (rst),
        .branch (ctl.branch),
        .equal  (alu_zero),
        .jump   (ctl.jump),
        .offset (f_imm),
        .target (f_tgt),
        .pc     (pc)
    );

    assign dbg_pc    = pc;
    assign is_branch = ctl.branch;
    assign is_jump   = ctl.jump;
    assign is_store  = ctl.mem_we;

    assign unused_bits = ^instr[10:6];
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] dbg_pc,
    input logic [RIDX-1:0] dbg_reg_sel,
    input logic [XLEN-1:0] dbg_reg_data,
    input logic [XLEN-1:0] instr,
    input logic            is_branch,
    input logic            is_jump,
    input logic            is_store,
    input logic            alu_zero,
    input logic            rf_we
);
    // R1
    pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dbg_pc == '0));

    // R8
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_branch && !is_jump) |=> (dbg_pc == $past(dbg_pc) + 32'd4));

    // R6
    br_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (is_branch && alu_zero) |=>
        (dbg_pc == $past(dbg_pc) + 32'd4 +
                   {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    // R6
    br_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (is_branch && !alu_zero) |=> (dbg_pc == $past(dbg_pc) + 32'd4));

    // R7
    jump_dest_chk: assert property (@(posedge clk) disable iff (rst)
        is_jump |=> (dbg_pc == {$past(dbg_pc[31:28] + 4'(dbg_pc[27:2] == 26'h3FFFFFF)),
                                $past(instr[25:0]), 2'b00}));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (dbg_reg_sel == '0) |-> (dbg_reg_data == '0));

    // R5
    store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        is_store |-> !rf_we);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dbg_pc       (dbg_pc),
    .dbg_reg_sel  (dbg_reg_sel),
    .dbg_reg_data (dbg_reg_data),
    .instr        (instr),
    .is_branch    (is_branch),
    .is_jump      (is_jump),
    .is_store     (is_store),
    .alu_zero     (alu_zero),
    .rf_we        (rf_we)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
    localparam int IW = 6;
    localparam int NPROG = 19;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [IW-1:0] prog_addr = '0;
    logic [31:0] prog_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [31:0] dbg_pc;

    int n_chk = 0;
    int n_bad = 0;
    logic mon_go = 1'b0;

    logic [31:0] exp_pc_q[$];
    string       exp_tag_q[$];
    logic [31:0] prog [NPROG];

    always #2 clk = ~clk;

    sc_core uut (
        .clk          (clk),
        .rst          (rst),
        .prog_we      (prog_we),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'd0, fn};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push_pc(input logic [31:0] pcv, input string tag);
        exp_pc_q.push_back(pcv);
        exp_tag_q.push_back(tag);
    endtask

    task automatic rd_reg(input logic [4:0] sel, input logic [31:0] exp, input string tag);
        dbg_reg_sel = sel;
        #1;
        chk(tag, dbg_reg_data, exp);
    endtask

    // Monitor: pops expected PCs and compares once per cycle
    initial begin
        logic [31:0] e;
        string t;
        wait (mon_go);
        forever begin
            if (exp_pc_q.size() > 0) begin
                e = exp_pc_q.pop_front();
                t = exp_tag_q.pop_front();
                chk(t, dbg_pc, e);
            end
            @(negedge clk);
            #1;
        end
    end

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog expired, actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Program (word index: instruction)
        prog[0]  = enc_i(6'b001101, 5'd0, 5'd1, 16'h0005);   // R3 r1 = 5
        prog[1]  = enc_i(6'b001101, 5'd0, 5'd2, 16'h8003);   // R3 zero-extended
        prog[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100000);       // R2 add
        prog[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100010);       // R2 sub, wraps
        prog[4]  = enc_i(6'b001101, 5'd0, 5'd5, 16'h0020);   // r5 = 32
        prog[5]  = enc_i(6'b101011, 5'd5, 5'd4, 16'hFFFC);   // R5 store at 28
        prog[6]  = enc_i(6'b100011, 5'd5, 5'd6, 16'hFFFC);   // R4 load from 28
        prog[7]  = enc_i(6'b001101, 5'd1, 5'd0, 16'h00FF);   // R9 write r0
        prog[8]  = enc_r(5'd0, 5'd1, 5'd7, 6'b100000);       // R9 r7 = r0 + r1
        prog[9]  = enc_i(6'b000100, 5'd1, 5'd2, 16'h0005);   // R6 not taken
        prog[10] = enc_i(6'b000100, 5'd6, 5'd4, 16'h0002);   // R6 taken forward
        prog[11] = enc_i(6'b001101, 5'd0, 5'd8, 16'h0BAD);   // skipped
        prog[12] = enc_i(6'b001101, 5'd0, 5'd8, 16'h0BAD);   // skipped
        prog[13] = 32'hFC00_0000;                            // R10 unknown opcode
        prog[14] = enc_r(5'd1, 5'd2, 5'd9, 6'b101010);       // R10 unknown function
        prog[15] = {6'b000010, 26'd18};                      // R7 jump to word 18
        prog[16] = enc_i(6'b001101, 5'd0, 5'd10, 16'h0BAD);  // skipped
        prog[17] = enc_i(6'b001101, 5'd0, 5'd10, 16'h0BAD);  // skipped
        prog[18] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFC);   // R6 taken backward

        // R11: load through the program port while in reset
        for (int i = 0; i < NPROG; i++) begin
            @(negedge clk);
            prog_we   = 1'b1;
            prog_addr = IW'(i);
            prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        #1;
        chk("R1 pc held at 0 in reset", dbg_pc, 32'd0);
        rd_reg(5'd1, 32'd0, "R1 register clear in reset");

        // Expected PC trace (scoreboard)
        push_pc(32'd0,  "R1 first fetch at 0");
        push_pc(32'd4,  "R8 after ori");
        push_pc(32'd8,  "R8 after ori");
        push_pc(32'd12, "R8 after add");
        push_pc(32'd16, "R8 after sub");
        push_pc(32'd20, "R8 after ori");
        push_pc(32'd24, "R8 after store");
        push_pc(32'd28, "R8 after load");
        push_pc(32'd32, "R8 after write to r0");
        push_pc(32'd36, "R8 after add");
        push_pc(32'd40, "R6 branch not taken");
        push_pc(32'd52, "R6 branch taken forward");
        push_pc(32'd56, "R10 unknown opcode advances");
        push_pc(32'd60, "R10 unknown function advances");
        push_pc(32'd72, "R7 jump target");
        push_pc(32'd60, "R6 branch taken backward");
        push_pc(32'd72, "R7 jump target again");
        push_pc(32'd60, "R6 backward again");

        @(negedge clk);
        rst = 1'b0;
        #1;
        mon_go = 1'b1;
        wait (exp_pc_q.size() == 0);
        @(negedge clk);
        #1;

        rd_reg(5'd1,  32'h0000_0005, "R3 ori result");
        rd_reg(5'd2,  32'h0000_8003, "R3 zero extension");
        rd_reg(5'd3,  32'h0000_8008, "R2 add");
        rd_reg(5'd4,  32'hFFFF_8002, "R2 sub wrap / R5 source unchanged");
        rd_reg(5'd5,  32'h0000_0020, "R3 base register");
        rd_reg(5'd6,  32'hFFFF_8002, "R4 load of stored word");
        rd_reg(5'd31, 32'd0,         "R5 store writes no register");
        rd_reg(5'd0,  32'd0,         "R9 r0 reads zero");
        rd_reg(5'd7,  32'h0000_0005, "R9 r0 operand is zero");
        rd_reg(5'd8,  32'd0,         "R6 skipped by taken branch");
        rd_reg(5'd9,  32'd0,         "R10 unknown function no write");
        rd_reg(5'd10, 32'd0,         "R7 skipped by jump");

        // R1: reset in the middle of a run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 mid-run reset pc", dbg_pc, 32'd0);
        rd_reg(5'd3, 32'd0, "R1 mid-run reset clears registers");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule